// File: doc/BRIEF.md
# Guarded Control Register Unlock Sequencer

This block holds a small control register whose persistent watchdog and block-protect fields can be changed only through a fixed three-step unlock ritual. A byte-level slave front end delivers each register access as a framed transaction: a start strobe that also says whether it is a write or a read, zero or more data-byte strobes, and a stop strobe. The block answers every data byte of a write transaction with an ACK or a NACK. It applies the single byte of a well-formed write only when the stop arrives.

Two volatile latches guard the persistent fields. A write of 02h raises the write-enable latch. A following write of 06h raises the register-write-enable latch. The third write then carries the new field values. If bit 2 of that byte is clear, the fields are loaded, the register-write-enable latch drops, and a cycle-count timer models the slow persistent write and holds `busy` while it runs. If bit 2 is set, the byte only keeps the unlock armed. Read transactions may be placed anywhere in the sequence without disturbing it. An attempted write to a protected memory block, reported on its own input, disarms the unlock.

Top module: `guarded_ctl_reg`

## Requirements
- R1: After reset, both latches are clear, `busy` is low, no ACK is pending, and the fields hold the reset parameters. `reg_view` always shows bit 7 = 0, bits 6:5 = watchdog, bits 4:3 = block-protect bits 2:1, bit 2 = register-write-enable latch, bit 1 = write-enable latch, and bit 0 = block-protect bit 0.
- R2: A write of 02h sets the write-enable latch, provided the unlock is not armed.
- R3: A write of exactly 06h sets the register-write-enable latch only when the write-enable latch is already set. Otherwise it is acknowledged and ignored.
- R4: When both latches are set, a write with bit 7 = 0, bit 1 = 1 and bit 2 = 0 commits the fields: watchdog from bits 6:5, and block-protect bits 2,1,0 from byte bits 4,3,0. The commit clears the register-write-enable latch and keeps the write-enable latch.
- R5: When both latches are set, a write of the same form with bit 2 = 1 leaves the fields and both latches unchanged.
- R6: Any other single-byte write is acknowledged and has no effect. This includes a final-form byte while the unlock is not armed, and a byte with bit 7 = 1 or bit 1 = 0 while it is armed.
- R7: In a write transaction, the second and any later data byte get a NACK, and the whole transaction is discarded.
- R8: Read transactions, and the bytes inside them, change no state and produce no ACK.
- R9: A write takes effect only at its stop. A new start discards the open transaction, and a stop with no data byte has no effect.
- R10: `busy` is high for exactly `NV_CYCLES` cycles after a commit. Write bytes that arrive while `busy` is high get a NACK, and their transaction has no effect.
- R11: A `prot_hit` pulse clears the register-write-enable latch. It wins over an arming write whose stop falls in the same cycle.
- R12: `ack_vld` pulses exactly one cycle after each data byte of a write transaction, with `ack_ok` = 1 for ACK and 0 for NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| txn_start | input | 1 | Start-of-transaction strobe |
| txn_wr | input | 1 | With `txn_start`: 1 = write, 0 = read |
| byte_vld | input | 1 | Data-byte strobe |
| byte_in | input | 8 | Data byte |
| txn_stop | input | 1 | End-of-transaction strobe |
| prot_hit | input | 1 | Attempted write to a protected block |
| ack_vld | output | 1 | ACK/NACK response valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Persistent write in progress |
| reg_view | output | 8 | Register contents in the R1 layout |

## Verification
The collision that matters is a `prot_hit` pulse landing in the same cycle as the stop of an 06h arming write. The bench drives both strobes on one edge and then expects `reg_view` to show the register-write-enable latch clear and the write-enable latch still set. A second overlap is a write transaction that opens while the commit timer is still running. The bench counts every cycle `busy` is high, requires the in-flight byte to be NACKed, and checks that the register is unchanged once the timer has expired.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
   localparam logic [7:0] OP_SET_WEL = 8'h02;
   localparam logic [7:0] OP_ARM     = 8'h06;

   typedef struct packed {
      logic [1:0] wd;
      logic [2:0] bp;
   } pfield_t;

   function automatic pfield_t fields_of(input logic [7:0] b);
      pfield_t r;
      r.wd = b[6:5];
      r.bp = {b[4], b[3], b[0]};
      return r;
   endfunction

   function automatic logic [7:0] view_of(input pfield_t f, input logic rwel, input logic wel);
      return {1'b0, f.wd, f.bp[2:1], rwel, wel, f.bp[0]};
   endfunction

   function automatic logic final_form(input logic [7:0] b);
      return !b[7] && b[1];
   endfunction
endpackage

// File: rtl/gcr_capture.sv
module gcr_capture #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic              txn_wr,
   input  logic              txn_stop,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              busy,
   output logic              ack_vld,
   output logic              ack_ok,
   output logic              done,
   output logic [BYTE_W-1:0] done_byte
);
   logic       open_wr;
   logic [1:0] cnt;
   logic       bad;
   logic       take;

   assign take      = byte_vld && open_wr && !txn_start && !txn_stop;
   assign done      = txn_stop && !txn_start && open_wr && (cnt == 2'd1) && !bad && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_wr   <= 1'b0;
         cnt       <= '0;
         bad       <= 1'b0;
         done_byte <= '0;
         ack_vld   <= 1'b0;
         ack_ok    <= 1'b0;
      end else begin
         ack_vld <= take;
         ack_ok  <= take && (cnt == 2'd0) && !busy;
         if (txn_start) begin
            open_wr <= txn_wr;
            cnt     <= '0;
            bad     <= 1'b0;
         end else if (txn_stop) begin
            open_wr <= 1'b0;
         end else if (take) begin
            if (cnt != 2'd2) cnt <= cnt + 2'd1;
            if (cnt == 2'd0) done_byte <= byte_in;
            if (busy) bad <= 1'b1;
         end
      end
   end

   assert_extra_byte_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cnt != 2'd0) |=> (ack_vld && !ack_ok));
   assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && busy) |=> !ack_ok);
   assert_ack_follows_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(byte_vld));
endmodule

// File: rtl/gcr_nvtimer.sv
module gcr_nvtimer #(
   parameter int NV_CYCLES = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (NV_CYCLES == 0) begin : g_instant
         assign busy = 1'b0;
      end else begin : g_count
         localparam int TMR_W = $clog2(NV_CYCLES + 1);
         localparam logic [TMR_W-1:0] LOAD = TMR_W'(NV_CYCLES);
         logic [TMR_W-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left <= '0;
            else if (start)      left <= LOAD;
            else if (left != '0) left <= left - 1'b1;
         end
         assign busy = (left != '0);

         assert_busy_from_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) |-> $past(start));
      end
   endgenerate
endmodule

// File: rtl/gcr_unlock.sv
module gcr_unlock
   import gcr_pkg::*;
#(
   parameter logic [1:0] RST_WD = 2'b01,
   parameter logic [2:0] RST_BP = 3'b101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic [7:0] done_byte,
   input  logic       prot_hit,
   output logic       wel,
   output logic       rwel,
   output pfield_t    fields,
   output logic       commit
);
   logic armed;
   logic arm_req;

   assign armed   = wel && rwel;
   assign commit  = done && armed && final_form(done_byte) && !done_byte[2];
   assign arm_req = done && !armed && wel && (done_byte == OP_ARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel       <= 1'b0;
         rwel      <= 1'b0;
         fields.wd <= RST_WD;
         fields.bp <= RST_BP;
      end else begin
         if (done && !armed && done_byte == OP_SET_WEL) wel <= 1'b1;
         if (commit) fields <= fields_of(done_byte);
         if (prot_hit || commit) rwel <= 1'b0;
         else if (arm_req)       rwel <= 1'b1;
      end
   end

   assert_rwel_implies_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rwel |-> wel);
   assert_fields_need_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fields) |-> ($past(rwel) && !rwel));
   assert_prot_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      prot_hit |=> !rwel);
endmodule

// File: rtl/guarded_ctl_reg.sv
module guarded_ctl_reg
   import gcr_pkg::*;
#(
   parameter int         BYTE_W    = 8,
   parameter int         NV_CYCLES = 2000000,
   parameter logic [1:0] RST_WD    = 2'b01,
   parameter logic [2:0] RST_BP    = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic              txn_wr,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              txn_stop,
   input  logic              prot_hit,
   output logic              ack_vld,
   output logic              ack_ok,
   output logic              busy,
   output logic [BYTE_W-1:0] reg_view
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("guarded_ctl_reg: the register layout needs BYTE_W == 8");
      end
      if (NV_CYCLES < 0 || NV_CYCLES > (1 << 30)) begin : g_bad_cycles
         $error("guarded_ctl_reg: NV_CYCLES out of range");
      end
   endgenerate

   logic              done;
   logic [BYTE_W-1:0] done_byte;
   logic              wel, rwel, commit;
   pfield_t           fields;

   gcr_capture #(.BYTE_W(BYTE_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_wr(txn_wr),
      .txn_stop(txn_stop), .byte_vld(byte_vld), .byte_in(byte_in), .busy(busy),
      .ack_vld(ack_vld), .ack_ok(ack_ok), .done(done), .done_byte(done_byte)
   );

   gcr_unlock #(.RST_WD(RST_WD), .RST_BP(RST_BP)) u_seq (
      .clk(clk), .rst_n(rst_n), .done(done), .done_byte(done_byte[7:0]),
      .prot_hit(prot_hit), .wel(wel), .rwel(rwel), .fields(fields), .commit(commit)
   );

   gcr_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
   );

   assign reg_view = view_of(fields, rwel, wel);

   assert_stop_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_view) |-> ($past(txn_stop) || $past(prot_hit)));
endmodule

// File: tb/sim_guarded_ctl_reg.sv
module sim_guarded_ctl_reg;
   localparam int NVC = 6;
   localparam int KW1 = 0, KW2 = 1, KRD = 2, KPH = 3;
   localparam int NV = 14;
   // entry: {kind[1:0], byte[7:0], exp_ack, exp_view[7:0], req[3:0]}
   localparam logic [22:0] VEC [NV] = '{
      {2'd0, 8'h06, 1'b1, 8'h31, 4'd3},   // R3 ARM without WEL ignored
      {2'd0, 8'h02, 1'b1, 8'h33, 4'd2},   // R2
      {2'd2, 8'h00, 1'b0, 8'h33, 4'd8},   // R8 read between steps
      {2'd0, 8'h06, 1'b1, 8'h37, 4'd3},   // R3
      {2'd2, 8'h00, 1'b0, 8'h37, 4'd8},   // R8
      {2'd0, 8'h06, 1'b1, 8'h37, 4'd5},   // R5 re-arm only
      {2'd0, 8'h02, 1'b1, 8'h02, 4'd4},   // R4 commit zeros
      {2'd0, 8'h06, 1'b1, 8'h06, 4'd3},   // R3
      {2'd1, 8'h4B, 1'b0, 8'h06, 4'd7},   // R7 second byte aborts
      {2'd3, 8'h00, 1'b0, 8'h02, 4'd11},  // R11
      {2'd0, 8'h7B, 1'b1, 8'h02, 4'd6},   // R6 not armed
      {2'd0, 8'h06, 1'b1, 8'h06, 4'd3},   // R3
      {2'd0, 8'h83, 1'b1, 8'h06, 4'd6},   // R6 bad form while armed
      {2'd0, 8'h7B, 1'b1, 8'h7B, 4'd4}    // R4 commit fields
   };

   logic clk = 0, rst_n = 0;
   logic txn_start = 0, txn_wr = 0, byte_vld = 0, txn_stop = 0, prot_hit = 0;
   logic [7:0] byte_in = 0;
   logic ack_vld, ack_ok, busy;
   logic [7:0] reg_view;
   int checks = 0, errors = 0, cyc = 0, busy_cnt = 0;
   bit first_ack, last_ack, ack_seen;

   always #2.5 clk = ~clk;

   guarded_ctl_reg #(.NV_CYCLES(NVC), .RST_WD(2'b01), .RST_BP(3'b101)) u0 (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_wr(txn_wr),
      .byte_vld(byte_vld), .byte_in(byte_in), .txn_stop(txn_stop),
      .prot_hit(prot_hit), .ack_vld(ack_vld), .ack_ok(ack_ok), .busy(busy),
      .reg_view(reg_view)
   );

   always @(negedge clk) begin
      cyc++;
      if (busy) busy_cnt++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic txn(input bit wr, input int n, input logic [7:0] b, input bit ph);
      @(negedge clk); txn_start = 1; txn_wr = wr;
      @(negedge clk); txn_start = 0;
      ack_seen = 0; first_ack = 0; last_ack = 0;
      for (int i = 0; i < n; i++) begin
         byte_vld = 1; byte_in = b;
         @(negedge clk); byte_vld = 0;
         if (ack_vld) ack_seen = 1;
         if (i == 0) first_ack = ack_ok;
         last_ack = ack_ok;
      end
      txn_stop = 1; prot_hit = ph;
      @(negedge clk); txn_stop = 0; prot_hit = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(reg_view == 8'h31, "R1 view", reg_view, 8'h31);
      chk(!busy && !ack_vld, "R1 busy/ack", {busy, ack_vld}, 0);

      for (int v = 0; v < NV; v++) begin
         logic [1:0] k;
         logic [7:0] b, ev;
         logic ea;
         string tag;
         {k, b, ea, ev} = VEC[v][22:4];
         tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
         if (k == KPH) begin
            @(negedge clk); prot_hit = 1;
            @(negedge clk); prot_hit = 0;
         end else if (k == KRD) begin
            txn(0, 1, 8'hA5, 0);
            chk(!ack_seen, {tag, " read ack"}, ack_seen, 0);
         end else begin
            txn(1, (k == KW2) ? 2 : 1, b, 0);
            chk(ack_seen && last_ack == ea, {tag, " ack"}, last_ack, ea);
            if (k == KW2) chk(first_ack, "R7 first byte ack", first_ack, 1);
         end
         chk(reg_view == ev, {tag, " view"}, reg_view, ev);
         repeat (NVC + 2) @(negedge clk);
      end

      // R10: commit, then a write during busy is NACKed and ignored
      txn(1, 1, 8'h06, 0);
      chk(reg_view == 8'h7F, "R3 arm again", reg_view, 8'h7F);
      busy_cnt = 0;
      txn(1, 1, 8'h02, 0);
      chk(reg_view == 8'h02, "R4 commit", reg_view, 8'h02);
      txn(1, 1, 8'h06, 0);
      chk(!last_ack, "R10 nack while busy", last_ack, 0);
      repeat (NVC + 2) @(negedge clk);
      chk(reg_view == 8'h02, "R10 busy write ignored", reg_view, 8'h02);
      chk(busy_cnt == NVC, "R10 busy length", busy_cnt, NVC);

      // R11: protected-block hit on the same edge as the arming stop
      txn(1, 1, 8'h06, 1);
      chk(reg_view == 8'h02, "R11 collision", reg_view, 8'h02);

      // R9: restart discards the open write; empty stop does nothing
      @(negedge clk); txn_start = 1; txn_wr = 1;
      @(negedge clk); txn_start = 0; byte_vld = 1; byte_in = 8'h06;
      @(negedge clk); byte_vld = 0; txn_start = 1; txn_wr = 1;
      @(negedge clk); txn_start = 0; txn_stop = 1;
      @(negedge clk); txn_stop = 0;
      chk(reg_view == 8'h02, "R9 restart/empty stop", reg_view, 8'h02);

      // R9: nothing before the stop
      @(negedge clk); txn_start = 1; txn_wr = 1;
      @(negedge clk); txn_start = 0; byte_vld = 1; byte_in = 8'h06;
      @(negedge clk); byte_vld = 0;
      chk(ack_vld && ack_ok, "R12 ack one cycle later", {ack_vld, ack_ok}, 3);
      @(negedge clk);
      chk(reg_view == 8'h02 && !ack_vld, "R9 no effect before stop", reg_view, 8'h02);
      txn_stop = 1;
      @(negedge clk); txn_stop = 0;
      chk(reg_view == 8'h06, "R9 effect at stop", reg_view, 8'h06);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule